// File: doc/BRIEF.md
# Memory-Mapped GCD Coprocessor

This block computes the greatest common divisor of two unsigned 32-bit operands. It sits behind a simple word-addressed slave port. Host software reaches it through five registers. A typical job runs as follows. Software pulses the soft-reset bit and loads both operands. It then raises the enable bit and polls the status word until the done flag appears. It reads the result, and finally writes zero to the control word.

The engine runs the binary (shift-and-subtract) GCD method, one step per clock. The number of steps is therefore bounded by the operand width and not by the operand values. A computation starts only on a rising edge of the enable bit. Leaving enable high does not restart the engine. The result and the done flag hold until a soft reset or a new start.

Top module: `gcd_mm_accel`

## Requirements
- R1: A read cycle (cs=1, wr=0) returns the addressed register on `rdata` one clock after the edge that captures it. In every other cycle `rdata` is zero. The operand A register (offset 2) and the operand B register (offset 3) read back the last values written to them.
- R2: A 0-to-1 transition of control bit 0 (offset 1) starts a computation. The result register (offset 4) then holds gcd(A, B) of the operands present at the start.
- R3: When one operand is zero, the result is the other operand. gcd(0,0) is 0.
- R4: Status (offset 0) reads 0 from the second edge after the enable write until the computation ends. After that it reads exactly 1, with bit 0 being the done flag.
- R5: Once done, the done flag and the result stay unchanged while enable is held high. They also stay unchanged after control is cleared to zero. Rewriting 1 over an already-set enable bit starts nothing.
- R6: Control bit 1 is a soft reset. While it is set, the engine goes idle, done reads 0, the result reads 0, and an enable rising edge written together with it is discarded.
- R7: Reads of offsets 5, 6 and 7 return zero. Writes to them change no register.
- R8: The done flag is visible to a status read captured no later than 2*W+2 edges after the edge that captured the enable write (W = 32).
- R9: A synchronous active-high reset clears every register, so that all eight offsets read zero.
- R10: Control reads back only bits 1:0 as written, with the upper bits reading as zero. Writes to the result register (offset 4) are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Slave select |
| addr | input | 3 | Word address |
| wr | input | 1 | Write strobe; a selected cycle with wr low is a read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |

## Verification
Register writes land on the edge that captures them. Control writes reach the engine one edge later. Read data appears one edge after the read is captured. For these reasons every bus write in the bench is followed by an idle cycle, and every read is sampled on the falling edge that follows its capture edge.

The finishing time of a computation depends on the data. The bench therefore polls status, counting reads, and checks that count against the 2*W+2 edge bound. It then reads the result and checks it against a Euclid reference model in the bench. Hold and soft-reset behaviour is checked with reads taken after long idle gaps.

// File: rtl/gcd_mm_pkg.sv
package gcd_mm_pkg;

  typedef enum logic [2:0] {
    REG_STAT = 3'd0,
    REG_CTRL = 3'd1,
    REG_OPA  = 3'd2,
    REG_OPB  = 3'd3,
    REG_RES  = 3'd4
  } reg_addr_e;

  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_SRST_BIT = 1;

  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_RUN  = 2'd1,
    ENG_DONE = 2'd2
  } eng_state_e;

endpackage

// File: rtl/gcd_mm_core.sv
module gcd_mm_core
  import gcd_mm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  input  logic         start,
  input  logic [W-1:0] opa,
  input  logic [W-1:0] opb,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] result
);
  localparam int KW = (W > 2) ? $clog2(W) : 1;

  eng_state_e    state;
  logic [W-1:0]  a_q, b_q;
  logic [KW-1:0] k_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      state  <= ENG_IDLE;
      a_q    <= '0;
      b_q    <= '0;
      k_q    <= '0;
      result <= '0;
    end else if (start) begin
      a_q   <= opa;
      b_q   <= opb;
      k_q   <= '0;
      state <= ENG_RUN;
    end else if (state == ENG_RUN) begin
      if (a_q == '0) begin
        result <= b_q << k_q;
        state  <= ENG_DONE;
      end else if (b_q == '0) begin
        result <= a_q << k_q;
        state  <= ENG_DONE;
      end else if (!a_q[0] && !b_q[0]) begin
        a_q <= a_q >> 1;
        b_q <= b_q >> 1;
        k_q <= k_q + 1'b1;
      end else if (!a_q[0]) begin
        a_q <= a_q >> 1;
      end else if (!b_q[0]) begin
        b_q <= b_q >> 1;
      end else if (a_q >= b_q) begin
        a_q <= (a_q - b_q) >> 1;
      end else begin
        b_q <= (b_q - a_q) >> 1;
      end
    end
  end

  assign busy = (state == ENG_RUN);
  assign done = (state == ENG_DONE);

endmodule

// File: rtl/gcd_mm_regs.sv
module gcd_mm_regs
  import gcd_mm_pkg::*;
#(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  input  logic          done,
  input  logic [W-1:0]  result,
  output logic [W-1:0]  rdata,
  output logic          ctrl_en,
  output logic          ctrl_srst,
  output logic [W-1:0]  op_a,
  output logic [W-1:0]  op_b
);
  logic [W-1:0] rd_mux;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_en   <= 1'b0;
      ctrl_srst <= 1'b0;
      op_a      <= '0;
      op_b      <= '0;
    end else if (cs && wr) begin
      case (reg_addr_e'(addr))
        REG_CTRL: begin
          ctrl_en   <= wdata[CTRL_EN_BIT];
          ctrl_srst <= wdata[CTRL_SRST_BIT];
        end
        REG_OPA: op_a <= wdata;
        REG_OPB: op_b <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr_e'(addr))
      REG_STAT: rd_mux[0] = done;
      REG_CTRL: begin
        rd_mux[CTRL_EN_BIT]   = ctrl_en;
        rd_mux[CTRL_SRST_BIT] = ctrl_srst;
      end
      REG_OPA: rd_mux = op_a;
      REG_OPB: rd_mux = op_b;
      REG_RES: rd_mux = result;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= (cs && !wr) ? rd_mux : '0;
  end

endmodule

// File: rtl/gcd_mm_accel.sv
module gcd_mm_accel #(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs,
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic         ctrl_en_w, ctrl_srst_w, en_prev;
  logic         start_w, busy_w, done_w;
  logic [W-1:0] opa_w, opb_w, res_w;

  gcd_mm_regs #(.W(W), .AW(AW)) u_regs (
    .clk      (clk),
    .rst      (rst),
    .cs       (cs),
    .addr     (addr),
    .wr       (wr),
    .wdata    (wdata),
    .done     (done_w),
    .result   (res_w),
    .rdata    (rdata),
    .ctrl_en  (ctrl_en_w),
    .ctrl_srst(ctrl_srst_w),
    .op_a     (opa_w),
    .op_b     (opb_w)
  );

  always_ff @(posedge clk) begin
    if (rst) en_prev <= 1'b0;
    else     en_prev <= ctrl_en_w;
  end

  assign start_w = ctrl_en_w && !en_prev && !ctrl_srst_w;

  gcd_mm_core #(.W(W)) u_core (
    .clk   (clk),
    .rst   (rst),
    .clr   (ctrl_srst_w),
    .start (start_w),
    .opa   (opa_w),
    .opb   (opb_w),
    .busy  (busy_w),
    .done  (done_w),
    .result(res_w)
  );

endmodule

// File: rtl/gcd_mm_accel_chk.sv
module gcd_mm_accel_chk #(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          cs,
  input logic [AW-1:0] addr,
  input logic          wr,
  input logic [W-1:0]  rdata,
  input logic          start,
  input logic          srst,
  input logic          busy,
  input logic          done,
  input logic [W-1:0]  result
);
  localparam int LIM = 2 * W + 1;
  localparam int CW  = $clog2(LIM + 2) + 1;

  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || srst)  run_cnt <= '0;
    else if (start)   run_cnt <= CW'(1);
    else if (busy)    run_cnt <= run_cnt + 1'b1;
    else              run_cnt <= '0;
  end

  // R1: data bus is quiet outside read replies
  a_r1_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !(cs && !wr) |=> rdata == '0);

  // R2: a start puts the engine to work and withdraws done
  a_r2_start_runs: assert property (@(posedge clk) disable iff (rst)
    start |=> busy && !done);

  // R4: never busy and done together
  always @(posedge clk) begin
    if (!rst) a_r4_excl: assert (!(busy && done));
  end

  // R5: done and result hold without a start or soft reset
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    done && !start && !srst |=> done && $stable(result));

  // R6: soft reset idles the engine and clears the result
  a_r6_srst_idle: assert property (@(posedge clk) disable iff (rst)
    srst |=> !busy && !done && result == '0);

  // R7: unused offsets read zero
  a_r7_unused_zero: assert property (@(posedge clk) disable iff (rst)
    cs && !wr && addr > AW'(4) |=> rdata == '0);

  // R8: run length bounded by operand width
  a_r8_bound: assert property (@(posedge clk) disable iff (rst)
    busy |-> run_cnt <= CW'(LIM));

endmodule

bind gcd_mm_accel gcd_mm_accel_chk #(.W(W), .AW(AW)) u_chk (
  .clk   (clk),
  .rst   (rst),
  .cs    (cs),
  .addr  (addr),
  .wr    (wr),
  .rdata (rdata),
  .start (start_w),
  .srst  (ctrl_srst_w),
  .busy  (busy_w),
  .done  (done_w),
  .result(res_w)
);

// File: tb/gcd_mm_accel_tb.sv
module gcd_mm_accel_tb;
  localparam int W = 32;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cs = 1'b0;
  logic         wr = 1'b0;
  logic [2:0]   addr = '0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata;

  int n_chk = 0;
  int n_err = 0;

  typedef struct {
    logic [W-1:0] exp;
    bit           chk;
    int           req;
  } item_t;
  item_t sb_q[$];
  logic  rd_seen = 1'b0;

  always #10 clk = ~clk;

  gcd_mm_accel #(.W(W), .AW(3)) u_dut (
    .clk(clk), .rst(rst), .cs(cs), .addr(addr),
    .wr(wr), .wdata(wdata), .rdata(rdata)
  );

  task automatic check(input int r, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL R%0d: actual=%h expected=%h", r, act, exp);
    end
  endtask

  // monitor: pops the expected item matching each read reply
  always @(posedge clk) rd_seen <= cs && !wr && !rst;
  always @(negedge clk) begin
    if (rd_seen && sb_q.size() != 0) begin
      item_t it;
      it = sb_q.pop_front();
      if (it.chk) check(it.req, rdata, it.exp);
    end
  end

  function automatic logic [W-1:0] gold(input logic [W-1:0] x, input logic [W-1:0] y);
    logic [W-1:0] p, q, t;
    p = x; q = y;
    while (q != 0) begin
      t = p % q; p = q; q = t;
    end
    return p;
  endfunction

  task automatic bus_wr(input logic [2:0] a, input logic [W-1:0] d);
    cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic bus_rd(input logic [2:0] a, input logic [W-1:0] exp, input bit do_chk,
                        input int r, output logic [W-1:0] v);
    item_t it;
    it.exp = exp; it.chk = do_chk; it.req = r;
    cs = 1'b1; wr = 1'b0; addr = a;
    sb_q.push_back(it);
    @(negedge clk);
    v = rdata;
    cs = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [W-1:0] exp, input int r);
    logic [W-1:0] v;
    bus_rd(a, exp, 1'b1, r, v);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poll_done(output int n);
    logic [W-1:0] v;
    n = 0;
    do begin
      bus_rd(3'd0, '0, 1'b0, 4, v);
      n++;
    end while (v == '0 && n < 4 * W);
    check(4, v, 32'd1);   // R4: done status reads exactly 1
  endtask

  task automatic run_gcd(input logic [W-1:0] x, input logic [W-1:0] y, input int r);
    int n;
    logic [W-1:0] g;
    g = gold(x, y);
    bus_wr(3'd1, 32'd2);
    bus_wr(3'd2, x);
    bus_wr(3'd3, y);
    bus_wr(3'd1, 32'd1);
    rd_chk(3'd0, 32'd0, 4);          // R4: busy reads zero
    poll_done(n);
    check(8, W'(n <= 2 * W), 32'd1); // R8: first read + n polls within bound
    rd_chk(3'd4, g, r);              // R2/R3 result
    bus_wr(3'd1, 32'd0);
    rd_chk(3'd0, 32'd1, 5);          // R5: clearing control keeps done
    rd_chk(3'd4, g, 5);              // R5: and the result
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R8: watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    idle(3);
    rst = 1'b0;
    idle(1);
    // R9: reset state
    check(9, rdata, '0);
    for (int i = 0; i < 8; i++) rd_chk(3'(i), '0, 9);

    // R1: operand readback and quiet bus
    bus_wr(3'd2, 32'hDEAD_BEEF);
    bus_wr(3'd3, 32'h1234_5678);
    rd_chk(3'd2, 32'hDEAD_BEEF, 1);
    rd_chk(3'd3, 32'h1234_5678, 1);
    idle(1);
    check(1, rdata, '0);

    // R10: control readback width
    bus_wr(3'd1, 32'hFFFF_FFFF);
    rd_chk(3'd1, 32'd3, 10);
    bus_wr(3'd1, 32'd0);
    rd_chk(3'd1, 32'd0, 10);

    // R7: unused offsets
    bus_wr(3'd5, 32'hAAAA_AAAA);
    bus_wr(3'd7, 32'h5555_5555);
    rd_chk(3'd5, '0, 7);
    rd_chk(3'd6, '0, 7);
    rd_chk(3'd7, '0, 7);
    rd_chk(3'd2, 32'hDEAD_BEEF, 7);
    rd_chk(3'd3, 32'h1234_5678, 7);

    // R2: general operand pairs
    run_gcd(32'd48, 32'd18, 2);
    run_gcd(32'd17, 32'd13, 2);
    run_gcd(32'd1024, 32'd768, 2);
    run_gcd(32'd270, 32'd192, 2);
    run_gcd(32'h8000_0000, 32'h4000_0000, 2);
    run_gcd(32'hFFFF_FFFF, 32'hFFFF_FFFF, 2);
    run_gcd(32'd1, 32'hFFFF_FFFE, 2);
    run_gcd(32'hFFFF_FFFF, 32'd3, 2);
    // R3: zero operands
    run_gcd(32'd0, 32'd7, 3);
    run_gcd(32'd9, 32'd0, 3);
    run_gcd(32'd0, 32'd0, 3);

    // R10: result register is read-only; R7: unused write leaves operands
    run_gcd(32'd84, 32'd36, 2);
    bus_wr(3'd4, 32'h55);
    rd_chk(3'd4, 32'd12, 10);
    bus_wr(3'd6, 32'hFFFF);
    rd_chk(3'd2, 32'd84, 7);
    rd_chk(3'd3, 32'd36, 7);

    // R5: held enable does not restart
    begin
      int n;
      bus_wr(3'd1, 32'd1);
      poll_done(n);
      bus_wr(3'd2, 32'd100);
      idle(20);
      rd_chk(3'd0, 32'd1, 5);
      rd_chk(3'd4, 32'd12, 5);
      bus_wr(3'd1, 32'd1);
      rd_chk(3'd0, 32'd1, 5);
      rd_chk(3'd4, 32'd12, 5);
      bus_wr(3'd1, 32'd0);
    end

    // R6: soft reset during and after a run
    bus_wr(3'd2, 32'd1);
    bus_wr(3'd3, 32'hFFFF_FFFF);
    bus_wr(3'd1, 32'd1);
    bus_wr(3'd1, 32'd2);
    rd_chk(3'd0, 32'd0, 6);
    idle(100);
    rd_chk(3'd0, 32'd0, 6);
    rd_chk(3'd4, 32'd0, 6);
    bus_wr(3'd1, 32'd0);
    bus_wr(3'd1, 32'd3);
    idle(100);
    rd_chk(3'd0, 32'd0, 6);
    rd_chk(3'd4, 32'd0, 6);
    bus_wr(3'd1, 32'd0);
    run_gcd(32'd35, 32'd21, 6);
    bus_wr(3'd1, 32'd2);
    rd_chk(3'd0, 32'd0, 6);
    rd_chk(3'd4, 32'd0, 6);
    bus_wr(3'd1, 32'd0);

    idle(2);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule